// File: doc/BRIEF.md
# Operand-Fetch Data Hazard Interlock

This block is the interlock controller for a five-stage in-order pipeline whose stages run fetch, operand fetch, execute, memory access and write back. It looks at the instruction sitting in operand fetch and compares the registers it reads against the destinations of multiplies that have already left for execute and whose product is not yet available. While a needed product is still being computed, the block freezes fetch and operand fetch together and feeds empty bubbles into execute. The older multiply keeps moving through execute, memory and write back in the meantime.

A per-register countdown scoreboard tracks the multiplies. When a multiply leaves operand fetch, its destination counter is loaded with `MulLatency - 1`. The counter then drops by one every cycle, and a reader of that register is held while the counter is nonzero. With the default latency of 2, a multiply in operand fetch in cycle 2 holds an adjacent dependent add, so the add occupies operand fetch in cycles 3 and 4 and reaches execute in cycle 5. Results from single-cycle producers are forwarded and never cause a stall. A branch redirect flush squashes the operand-fetch instruction and drops any stall it was waiting on.

Top module: `pipeHazardInterlock`

## Requirements
- R1: After reset no register is pending: `stallOperand`, `stallFetch` and `exIssue` are 0, and `exBubble` is 1 while `ofValid` is 0.
- R2: A valid instruction that reads register r through either source slot, issued g cycles after a multiply to r issued, is held for max(0, MulLatency-1-g) cycles. Issue cycles count as adjacent when g = 0.
- R3: Register index 0 never causes a stall, including after a multiply that names register 0 as its destination.
- R4: `stallFetch` equals `stallOperand` in every cycle.
- R5: `exIssue` is 1 exactly when `ofValid` is 1, `stallOperand` is 0 and `flush` is 0. `exBubble` is always the inverse of `exIssue`.
- R6: When `flush` is 1, `stallOperand` is 0 in that cycle and the squashed instruction leaves no trace in the scoreboard. A multiply that was already pending keeps counting down.
- R7: A single-cycle (`ofIsMul` = 0) writer to register r that issues after a multiply to r cancels the pending state of r. Single-cycle producers never stall a reader.
- R8: A source slot whose use flag (`ofUseA` / `ofUseB`) is 0 is ignored.
- R9: A later multiply to the same destination restarts that register's countdown at MulLatency-1.
- R10: A stall never lasts more than MulLatency-1 consecutive cycles, because the older multiply keeps progressing while the reader is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ofValid | input | 1 | Operand-fetch stage holds a valid instruction |
| ofRsA | input | RegIdxW | First source register index |
| ofUseA | input | 1 | First source is read |
| ofRsB | input | RegIdxW | Second source register index |
| ofUseB | input | 1 | Second source is read |
| ofRd | input | RegIdxW | Destination register index |
| ofWrite | input | 1 | Instruction writes its destination |
| ofIsMul | input | 1 | Instruction is a multi-cycle multiply |
| flush | input | 1 | Branch redirect squashes the operand-fetch instruction |
| stallFetch | output | 1 | Hold the fetch stage |
| stallOperand | output | 1 | Hold the operand-fetch stage |
| exBubble | output | 1 | Execute receives an empty slot next cycle |
| exIssue | output | 1 | Operand-fetch instruction moves into execute at this edge |

## Verification
The hardest situation to reach from the ports is a reader whose stall overlaps some other scoreboard event. Two such events matter:
- a flush that lands while a multiply is still pending, after which the next unflushed reader must still wait out the remaining count;
- a second multiply to the same destination that restarts the countdown.

The stimulus builds these as scripted instruction sequences, with inserted gap instructions that read only register 0 to control the cycle distance. A sweep over several destinations, both source slots and gaps of 0 to 3 cycles sets the expected stall length arithmetically to max(0, MulLatency-1-gap).

// File: rtl/pipeHazardPkg.sv
package pipeHazardPkg;

  // Strobes sent from the hazard control to the scoreboard datapath.
  typedef struct packed {
    logic       loadMul;   // multiply issued: start countdown on dstIdx
    logic       clearDst;  // single-cycle writer issued: cancel dstIdx
    logic [7:0] dstIdx;    // destination register index
  } sbStrobe_t;

endpackage

// File: rtl/hazardScoreboard.sv
module hazardScoreboard #(
  parameter int NumRegs    = 32,
  parameter int MulLatency = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pipeHazardPkg::sbStrobe_t strobe,
  output logic [NumRegs-1:0]       busy
);
  localparam int CntW = (MulLatency > 2) ? $clog2(MulLatency) : 1;
  localparam logic [CntW-1:0] LoadVal = CntW'(MulLatency - 1);

  // Register 0 is hard-wired: it never reads as pending.
  assign busy[0] = 1'b0;

  for (genvar r = 1; r < NumRegs; r++) begin : g_reg
    logic [CntW-1:0] remain;
    logic            hit;

    assign hit = (strobe.dstIdx == 8'(r));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        remain <= '0;
      end else if (strobe.loadMul && hit) begin
        remain <= LoadVal;
      end else if (strobe.clearDst && hit) begin
        remain <= '0;
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
      end
    end

    assign busy[r] = (remain != '0);
  end
endmodule

// File: rtl/hazardControl.sv
module hazardControl #(
  parameter int NumRegs = 32,
  parameter int RegIdxW = $clog2(NumRegs)
) (
  input  logic                      ofValid,
  input  logic [RegIdxW-1:0]        ofRsA,
  input  logic                      ofUseA,
  input  logic [RegIdxW-1:0]        ofRsB,
  input  logic                      ofUseB,
  input  logic [RegIdxW-1:0]        ofRd,
  input  logic                      ofWrite,
  input  logic                      ofIsMul,
  input  logic                      flush,
  input  logic [NumRegs-1:0]        busy,
  output logic                      holdOf,
  output logic                      issue,
  output pipeHazardPkg::sbStrobe_t  strobe
);
  logic hazA;
  logic hazB;
  logic dstLive;

  assign hazA    = ofUseA && (ofRsA != '0) && busy[ofRsA];
  assign hazB    = ofUseB && (ofRsB != '0) && busy[ofRsB];
  assign holdOf  = ofValid && !flush && (hazA || hazB);
  assign issue   = ofValid && !flush && !(hazA || hazB);
  assign dstLive = issue && ofWrite && (ofRd != '0);

  always_comb begin
    strobe          = '0;
    strobe.dstIdx   = 8'(ofRd);
    strobe.loadMul  = dstLive && ofIsMul;
    strobe.clearDst = dstLive && !ofIsMul;
  end
endmodule

// File: rtl/pipeHazardInterlock.sv
module pipeHazardInterlock #(
  parameter int NumRegs    = 32,
  parameter int MulLatency = 2,
  parameter int RegIdxW    = $clog2(NumRegs)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ofValid,
  input  logic [RegIdxW-1:0] ofRsA,
  input  logic               ofUseA,
  input  logic [RegIdxW-1:0] ofRsB,
  input  logic               ofUseB,
  input  logic [RegIdxW-1:0] ofRd,
  input  logic               ofWrite,
  input  logic               ofIsMul,
  input  logic               flush,
  output logic               stallFetch,
  output logic               stallOperand,
  output logic               exBubble,
  output logic               exIssue
);
  pipeHazardPkg::sbStrobe_t strobe;
  logic [NumRegs-1:0]       busy;
  logic                     holdOf;
  logic                     issue;

  hazardControl #(.NumRegs(NumRegs), .RegIdxW(RegIdxW)) ctrl_i (
    .ofValid (ofValid),
    .ofRsA   (ofRsA),
    .ofUseA  (ofUseA),
    .ofRsB   (ofRsB),
    .ofUseB  (ofUseB),
    .ofRd    (ofRd),
    .ofWrite (ofWrite),
    .ofIsMul (ofIsMul),
    .flush   (flush),
    .busy    (busy),
    .holdOf  (holdOf),
    .issue   (issue),
    .strobe  (strobe)
  );

  hazardScoreboard #(.NumRegs(NumRegs), .MulLatency(MulLatency)) sb_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .busy   (busy)
  );

  assign stallOperand = holdOf;
  assign stallFetch   = holdOf;
  assign exIssue      = issue;
  assign exBubble     = !issue;
endmodule

// File: rtl/pipeHazardInterlockChk.sv
module pipeHazardInterlockChk #(
  parameter int MulLatency = 2,
  parameter int RegIdxW    = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               ofValid,
  input logic [RegIdxW-1:0] ofRsA,
  input logic               ofUseA,
  input logic               ofUseB,
  input logic               flush,
  input logic               stallFetch,
  input logic               stallOperand,
  input logic               exBubble,
  input logic               exIssue
);
  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (stallOperand) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  AST_FETCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    stallFetch == stallOperand); // R4
  AST_ISSUE_NOT_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    exIssue |-> !exBubble && ofValid && !flush); // R5
  AST_FLUSH_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !stallOperand); // R6
  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    stallOperand |-> (32'(runLen) < MulLatency - 1)); // R10
  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (ofUseA && ofRsA == '0 && !ofUseB) |-> !stallOperand); // R3
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    !ofValid |-> !stallOperand && exBubble); // R5
endmodule

bind pipeHazardInterlock pipeHazardInterlockChk #(
  .MulLatency(MulLatency), .RegIdxW(RegIdxW)
) chk_i (
  .clk(clk), .rstN(rstN), .ofValid(ofValid), .ofRsA(ofRsA), .ofUseA(ofUseA),
  .ofUseB(ofUseB), .flush(flush), .stallFetch(stallFetch),
  .stallOperand(stallOperand), .exBubble(exBubble), .exIssue(exIssue)
);

// File: tb/pipeHazardInterlock_tb.sv
module pipeHazardInterlock_tb_top;
  localparam int Lat  = 3;
  localparam int IdxW = 5;

  logic clk = 1'b0;
  logic rstN;
  logic ofValid, ofUseA, ofUseB, ofWrite, ofIsMul, flush;
  logic [IdxW-1:0] ofRsA, ofRsB, ofRd;
  logic stallFetch, stallOperand, exBubble, exIssue;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pipeHazardInterlock #(.NumRegs(32), .MulLatency(Lat)) dut_i (
    .clk(clk), .rstN(rstN), .ofValid(ofValid), .ofRsA(ofRsA), .ofUseA(ofUseA),
    .ofRsB(ofRsB), .ofUseB(ofUseB), .ofRd(ofRd), .ofWrite(ofWrite),
    .ofIsMul(ofIsMul), .flush(flush), .stallFetch(stallFetch),
    .stallOperand(stallOperand), .exBubble(exBubble), .exIssue(exIssue)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    ofValid = 0; ofUseA = 0; ofUseB = 0; ofWrite = 0; ofIsMul = 0; flush = 0;
    ofRsA = '0; ofRsB = '0; ofRd = '0;
    repeat (n) @(negedge clk);
  endtask

  // Present one instruction at a negedge, hold it while stalled, count stalls.
  task automatic instr(int rsA, bit useA, int rsB, bit useB, int rd, bit wr,
                       bit mul, bit fl, int expStall, string req);
    int stalls = 0;
    bit done;
    ofValid = 1; ofRsA = IdxW'(rsA); ofUseA = useA; ofRsB = IdxW'(rsB);
    ofUseB = useB; ofRd = IdxW'(rd); ofWrite = wr; ofIsMul = mul; flush = fl;
    forever begin
      #1;
      if (stallFetch !== stallOperand) check("R4 fetch/operand stall", int'(stallFetch), int'(stallOperand));
      if (exIssue !== (!stallOperand && !fl)) check("R5 issue", int'(exIssue), int'(!stallOperand && !fl));
      if (exBubble !== !exIssue) check("R5 bubble", int'(exBubble), int'(!exIssue));
      if (stallOperand) stalls++;
      done = !stallOperand || stalls > 20;
      @(negedge clk);
      if (done) break;
    end
    check(req, stalls, expStall);
  endtask

  // Reader of register r following a multiply to r by g gap instructions.
  task automatic gapCase(int r, bit slotB, int g);
    int expS = (Lat - 1 - g > 0) ? Lat - 1 - g : 0;
    instr(0, 0, 0, 0, r, 1, 1, 0, 0, "R2 producer");
    for (int k = 0; k < g; k++) instr(0, 1, 0, 1, 0, 0, 0, 0, 0, "R3 gap reads r0");
    if (slotB) instr(0, 0, r, 1, 0, 0, 0, 0, expS, "R2 slot B dependent");
    else       instr(r, 1, 0, 0, 0, 0, 0, 0, expS, "R2 slot A dependent");
    idle(Lat);
  endtask

  initial begin
    rstN = 0;
    idle(3);
    #1;
    check("R1 stall after reset", int'(stallOperand), 0);
    check("R1 fetch stall after reset", int'(stallFetch), 0);
    check("R1 issue after reset", int'(exIssue), 0);
    check("R1 bubble after reset", int'(exBubble), 1);
    @(negedge clk);
    rstN = 1;
    idle(1);
    // After reset no register pending: reader of r5 flows through.
    instr(5, 1, 9, 1, 0, 0, 0, 0, 0, "R1 nothing pending");

    // Sweep destinations, both slots, gaps 0..3.
    for (int r = 1; r < 32; r += 6)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 4; g++)
          gapCase(r, s[0], g);

    // R3: multiply to r0 then read r0.
    instr(0, 0, 0, 0, 0, 1, 1, 0, 0, "R3 mul to r0");
    instr(0, 1, 0, 1, 0, 0, 0, 0, 0, "R3 read r0");
    idle(Lat);

    // R8: unused slot names the pending register.
    instr(0, 0, 0, 0, 9, 1, 1, 0, 0, "R8 producer");
    instr(9, 0, 9, 0, 0, 0, 0, 0, 0, "R8 unused slots ignored");
    instr(9, 1, 0, 0, 0, 0, 0, 0, Lat - 2, "R8 used slot still waits");
    idle(Lat);

    // R6: flushed reader drops its stall; pending mul keeps counting.
    instr(0, 0, 0, 0, 4, 1, 1, 0, 0, "R6 producer");
    instr(4, 1, 0, 0, 0, 0, 0, 1, 0, "R6 flushed reader not stalled");
    instr(4, 1, 0, 0, 0, 0, 0, 0, Lat - 2, "R6 countdown continued");
    idle(Lat);
    // R6: flushed multiply is not tracked.
    instr(0, 0, 0, 0, 12, 1, 1, 1, 0, "R6 flushed mul");
    instr(12, 1, 0, 0, 0, 0, 0, 0, 0, "R6 flushed mul leaves no trace");
    idle(Lat);

    // R7: single-cycle writer cancels pending; single-cycle producers never stall.
    instr(0, 0, 0, 0, 6, 1, 1, 0, 0, "R7 mul producer");
    instr(0, 0, 0, 0, 6, 1, 0, 0, 0, "R7 alu overwrite");
    instr(6, 1, 0, 0, 0, 0, 0, 0, 0, "R7 cancelled");
    instr(0, 0, 0, 0, 14, 1, 0, 0, 0, "R7 alu producer");
    instr(14, 1, 14, 1, 0, 0, 0, 0, 0, "R7 alu result forwarded");
    idle(Lat);

    // R9: second multiply restarts countdown.
    instr(0, 0, 0, 0, 7, 1, 1, 0, 0, "R9 first mul");
    instr(0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 gap");
    instr(0, 0, 0, 0, 7, 1, 1, 0, 0, "R9 second mul");
    instr(7, 1, 0, 0, 0, 0, 0, 0, Lat - 1, "R9 restarted count");
    idle(Lat);

    // R10: back-to-back dependents each bounded.
    instr(0, 0, 0, 0, 3, 1, 1, 0, 0, "R10 producer");
    instr(3, 1, 0, 0, 8, 1, 1, 0, Lat - 1, "R10 dependent mul");
    instr(8, 1, 3, 1, 0, 0, 0, 0, Lat - 1, "R10 chained dependent");
    idle(Lat);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule